// File: doc/BRIEF.md
# Single-Cycle 64-bit Subset Processor Core

This block is a small processor that finishes one whole instruction on every clock edge. It holds its own byte-addressed memory, which it uses for both code and data. On each cycle it takes an instruction from memory at the program counter. Instructions are 1 to 10 bytes long. The core reads up to two operands from a file of fifteen 64-bit registers and passes them through an adder/logic unit. It can then store eight bytes to memory, write one register, and move the program counter, all on the same edge.

The supported operations are:
- halt.
- Load-immediate.
- Register move, plus its six conditional forms that test the sign and zero flags.
- Four two-operand arithmetic/logic operations.
- A store of a register to base register plus a signed displacement.
- An unconditional jump.

A conditional move whose condition is false has its destination replaced by the "no register" code, so nothing is written.

Programs are loaded through a byte-wide load port. A register debug port and a memory debug port let the surroundings inspect results after the core halts.

Top module: `seq_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core sets `pc` to 0, clears `halted`, sets every register to 0, and sets the flags to sign=0 and zero=1. Memory is not cleared.
- R2: Instruction encoding:
  - Byte 0 holds the opcode in bits 7:4 and the function code in bits 3:0.
  - Byte 1, where present, holds the first register in bits 7:4 and the second register in bits 3:0.
  - All 8-byte constants are little-endian.
- R3: Load-immediate (opcode 3, function 0, byte 1 = F:rB) is 10 bytes long. It writes the 8-byte constant at pc+2 into rB and advances `pc` by 10.
- R4: Arithmetic (opcode 6) is 2 bytes long and writes its result into rB. The function code selects the operation:
  - 0: rB+rA.
  - 1: rB−rA.
  - 2: rB AND rA.
  - 3: rB XOR rA.
- R5: Only an arithmetic instruction updates the flags. Zero is set when the result is 0, and sign is set to result bit 63. Every other instruction leaves the flags unchanged.
- R6: Move (opcode 2) is 2 bytes long and copies rA into rB when its condition holds; otherwise no register changes. The function code selects the condition:
  - 0: always.
  - 1: sign OR zero.
  - 2: sign.
  - 3: zero.
  - 4: NOT zero.
  - 5: NOT sign.
  - 6: neither sign nor zero.
- R7: Store (opcode 4, function 0) is 10 bytes long. It writes rA as 8 little-endian bytes starting at rB plus the 8-byte displacement taken from pc+2. No register changes.
- R8: Jump (opcode 7, function 0) is 9 bytes long. It loads `pc` with the 8-byte destination found at pc+1.
- R9: Opcode 0 sets `halted`. So does any opcode/function pair not listed above. From then on, `pc`, the registers, the flags and memory stay frozen until reset, and `pc` keeps the address of the halting byte.
- R10: While `load_en` is high, `load_byte` is written to memory at `load_addr` and the core does not execute. Loading is allowed during reset.
- R11: Register code F is "no register". It reads as 0, and a write to it is discarded.
- R12: The debug outputs are combinational:
  - `dbg_reg_val` shows the register selected by `dbg_reg_sel` (0 for code F).
  - `dbg_mem_byte` shows the memory byte at `dbg_mem_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Program load strobe; stalls execution |
| load_addr | input | log2(MEM_BYTES) | Byte address for loading |
| load_byte | input | 8 | Byte to load |
| dbg_reg_sel | input | 4 | Register code to inspect |
| dbg_reg_val | output | 64 | Contents of selected register |
| dbg_mem_addr | input | log2(MEM_BYTES) | Memory byte to inspect |
| dbg_mem_byte | output | 8 | Contents of selected byte |
| pc | output | 64 | Program counter |
| halted | output | 1 | Core has stopped |

## Verification
The bench builds the core with its defaults: a 256-byte memory and 15 registers. With this size, the bench can reload the whole memory image before each program, so no bytes are left over from an earlier run.

The main checks are two sweeps:
- Every arithmetic function code against a 6×6 grid of operands that includes 0, the sign boundary and all-ones. Both the result and the resulting flags are checked, and the flags are read back through conditional moves.
- Every move condition against positive, negative and zero flag states.

Directed programs cover:
- The little-endian store at a base-plus-displacement address, including a negative displacement.
- Jumping past skipped code.
- The freeze after halt or after an illegal opcode.
- The execution stall while loading.
- Writes and reads of register code F.

// File: rtl/seq_pkg.sv
// seq_pkg: shared constants and types for the single-cycle core.
// Assumes a 64-bit datapath and 4-bit opcode/function/register fields.
package seq_pkg;

    localparam int XLEN        = 64;
    localparam int FETCH_BYTES = 10;
    localparam int LEN_SHORT   = 2;
    localparam int LEN_JUMP    = 9;
    localparam int LEN_LONG    = 10;

    localparam logic [3:0] OPC_HALT  = 4'h0;
    localparam logic [3:0] OPC_MOVE  = 4'h2;
    localparam logic [3:0] OPC_IMM   = 4'h3;
    localparam logic [3:0] OPC_STORE = 4'h4;
    localparam logic [3:0] OPC_ALU   = 4'h6;
    localparam logic [3:0] OPC_JUMP  = 4'h7;

    localparam logic [3:0] REG_NONE  = 4'hF;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_XOR = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic [3:0] opc;
        logic [3:0] fn;
        logic [3:0] ra;
        logic [3:0] rb;
    } insn_hdr_t;

    typedef struct packed {
        logic sf;
        logic zf;
    } flags_t;

endpackage

// File: rtl/seq_mem.sv
// seq_mem: byte-addressed unified memory for the core.
// Provides a combinational 10-byte fetch window at the PC, an 8-byte
// little-endian store port, a byte load port with priority over stores,
// and a combinational byte debug read. MEM_BYTES must be a power of two;
// addresses wrap modulo the memory size. Contents are not reset.
module seq_mem
    import seq_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input  logic                     clk,
    input  logic                     ld_en,
    input  logic [AW-1:0]            ld_addr,
    input  logic [7:0]               ld_byte,
    input  logic [XLEN-1:0]          fetch_pc,
    output logic [8*FETCH_BYTES-1:0] fetch_win,
    input  logic                     st_en,
    input  logic [XLEN-1:0]          st_addr,
    input  logic [XLEN-1:0]          st_data,
    input  logic [AW-1:0]            dbg_addr,
    output logic [7:0]               dbg_byte
);

    localparam int STORE_BYTES = XLEN / 8;

    logic [7:0]    mem [MEM_BYTES];
    logic [AW-1:0] pc_lo;
    logic [AW-1:0] st_base;

    assign pc_lo   = fetch_pc[AW-1:0];
    assign st_base = st_addr[AW-1:0];

    // Fetch window: byte i of the window is memory at pc+i (wrapping).
    for (genvar i = 0; i < FETCH_BYTES; i++) begin : g_fetch
        assign fetch_win[8*i +: 8] = mem[AW'(pc_lo + AW'(i))];
    end

    // Debug byte read.
    assign dbg_byte = mem[dbg_addr];

    // Memory update: loader first, otherwise an 8-byte little-endian store.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_byte;
        end else if (st_en) begin
            for (int k = 0; k < STORE_BYTES; k++) begin
                mem[AW'(st_base + AW'(k))] <= st_data[8*k +: 8];
            end
        end
    end

    // A store is never requested while the loader owns the memory.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            AST_LOAD_STORE_EXCL: assert (!st_en) else $error("store during load"); // R10
        end
    end

endmodule

// File: rtl/seq_regfile.sv
// seq_regfile: general register file with two read ports, one write port
// and a debug read port. Codes at or above NUM_REGS (including F) read as
// zero and ignore writes. Synchronous active-low reset clears all entries.
module seq_regfile
    import seq_pkg::*;
#(
    parameter int NUM_REGS = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      rd_a_sel,
    output logic [XLEN-1:0] rd_a_val,
    input  logic [3:0]      rd_b_sel,
    output logic [XLEN-1:0] rd_b_val,
    input  logic            wr_en,
    input  logic [3:0]      wr_sel,
    input  logic [XLEN-1:0] wr_data,
    input  logic [3:0]      dbg_sel,
    output logic [XLEN-1:0] dbg_val
);

    logic [XLEN-1:0] regs [NUM_REGS];

    // Read ports: out-of-range codes return zero.
    assign rd_a_val = (int'(rd_a_sel) < NUM_REGS) ? regs[rd_a_sel] : '0;
    assign rd_b_val = (int'(rd_b_sel) < NUM_REGS) ? regs[rd_b_sel] : '0;
    assign dbg_val  = (int'(dbg_sel)  < NUM_REGS) ? regs[dbg_sel]  : '0;

    // Register storage: clear on reset, single write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en && int'(wr_sel) < NUM_REGS) begin
            regs[wr_sel] <= wr_data;
        end
    end

    AST_DBG_SEES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_sel) < NUM_REGS && wr_sel == dbg_sel)
        |=> (dbg_sel != $past(dbg_sel)) || (dbg_val == $past(wr_data))); // R12

    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == REG_NONE && dbg_sel != REG_NONE)
        |=> (dbg_sel != $past(dbg_sel)) || $stable(dbg_val)); // R11

endmodule

// File: rtl/seq_alu.sv
// seq_alu: 64-bit add/subtract/and/xor unit with sign and zero flags.
// Subtraction computes b - a. Purely combinational.
module seq_alu
    import seq_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output flags_t          fl
);

    // Operation select.
    always_comb begin
        case (op)
            ALU_ADD: y = b + a;
            ALU_SUB: y = b - a;
            ALU_AND: y = b & a;
            default: y = b ^ a;
        endcase
    end

    // Flag generation from the result.
    always_comb begin
        fl.zf = (y == '0);
        fl.sf = y[XLEN-1];
    end

endmodule

// File: rtl/seq_cond.sv
// seq_cond: evaluates the move condition named by a function code against
// the sign and zero flags. Codes above 6 are reported as not legal.
module seq_cond
    import seq_pkg::*;
(
    input  logic [3:0] fn,
    input  flags_t     fl,
    output logic       take,
    output logic       legal
);

    // Condition table lookup.
    always_comb begin
        legal = 1'b1;
        case (fn)
            4'd0:    take = 1'b1;
            4'd1:    take = fl.sf | fl.zf;
            4'd2:    take = fl.sf;
            4'd3:    take = fl.zf;
            4'd4:    take = ~fl.zf;
            4'd5:    take = ~fl.sf;
            4'd6:    take = ~fl.sf & ~fl.zf;
            default: begin
                take  = 1'b0;
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seq_core.sv
// seq_core: single-cycle processor top. Each cycle it fetches one
// instruction at pc, decodes it, reads operands, computes through the ALU,
// optionally stores 8 bytes, writes back one register and updates pc.
// Assumes the program is loaded through the load port (during reset or
// while load_en stalls the core). Illegal encodings halt like opcode 0.
module seq_core
    import seq_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int NUM_REGS  = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic [$clog2(MEM_BYTES)-1:0] load_addr,
    input  logic [7:0]                   load_byte,
    input  logic [3:0]                   dbg_reg_sel,
    output logic [XLEN-1:0]              dbg_reg_val,
    input  logic [$clog2(MEM_BYTES)-1:0] dbg_mem_addr,
    output logic [7:0]                   dbg_mem_byte,
    output logic [XLEN-1:0]              pc,
    output logic                         halted
);

    logic [8*FETCH_BYTES-1:0] win;
    insn_hdr_t                hdr;
    logic [XLEN-1:0]          val_c;
    logic [XLEN-1:0]          rd_a, rd_b;
    logic [XLEN-1:0]          alu_a, alu_b, alu_y;
    alu_op_e                  alu_op;
    flags_t                   alu_fl;
    flags_t                   flags;
    logic                     cond_take, cond_legal;
    logic                     is_move, is_imm, is_store, is_alu, is_jump, legal;
    logic                     run;
    logic [3:0]               wr_sel;
    logic                     wr_en;
    logic                     st_en;
    logic [XLEN-1:0]          pc_next;

    assign run = !halted && !load_en;

    seq_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
        .clk       (clk),
        .ld_en     (load_en),
        .ld_addr   (load_addr),
        .ld_byte   (load_byte),
        .fetch_pc  (pc),
        .fetch_win (win),
        .st_en     (st_en),
        .st_addr   (alu_y),
        .st_data   (rd_a),
        .dbg_addr  (dbg_mem_addr),
        .dbg_byte  (dbg_mem_byte)
    );

    // Header fields: byte 0 opcode:function, byte 1 rA:rB.
    assign hdr = '{opc: win[7:4], fn: win[3:0], ra: win[15:12], rb: win[11:8]};

    // Constant field: follows byte 0 for jumps, byte 1 otherwise.
    assign val_c = (hdr.opc == OPC_JUMP) ? win[8 +: XLEN] : win[16 +: XLEN];

    seq_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_sel (hdr.ra),
        .rd_a_val (rd_a),
        .rd_b_sel (hdr.rb),
        .rd_b_val (rd_b),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (alu_y),
        .dbg_sel  (dbg_reg_sel),
        .dbg_val  (dbg_reg_val)
    );

    seq_cond u_cond (
        .fn    (hdr.fn),
        .fl    (flags),
        .take  (cond_take),
        .legal (cond_legal)
    );

    // Decode: classify the instruction and check its function code.
    always_comb begin
        is_move  = (hdr.opc == OPC_MOVE) && cond_legal;
        is_imm   = (hdr.opc == OPC_IMM)   && (hdr.fn == 4'd0);
        is_store = (hdr.opc == OPC_STORE) && (hdr.fn == 4'd0);
        is_alu   = (hdr.opc == OPC_ALU)   && (hdr.fn < 4'd4);
        is_jump  = (hdr.opc == OPC_JUMP)  && (hdr.fn == 4'd0);
        legal    = is_move | is_imm | is_store | is_alu | is_jump;
    end

    // Operand routing into the shared ALU.
    always_comb begin
        alu_a  = (is_imm || is_store) ? val_c : rd_a;
        alu_b  = (is_alu || is_store) ? rd_b  : '0;
        alu_op = is_alu ? alu_op_e'(hdr.fn[1:0]) : ALU_ADD;
    end

    seq_alu u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .op (alu_op),
        .y  (alu_y),
        .fl (alu_fl)
    );

    // Destination choice; a failed move condition drops to "no register".
    always_comb begin
        wr_sel = REG_NONE;
        if (is_imm || is_alu) begin
            wr_sel = hdr.rb;
        end else if (is_move && cond_take) begin
            wr_sel = hdr.rb;
        end
    end

    assign wr_en = run && (wr_sel != REG_NONE);
    assign st_en = run && is_store;

    // Next program counter from instruction length or jump target.
    always_comb begin
        pc_next = pc;
        if (is_move || is_alu) begin
            pc_next = pc + XLEN'(LEN_SHORT);
        end else if (is_imm || is_store) begin
            pc_next = pc + XLEN'(LEN_LONG);
        end else if (is_jump) begin
            pc_next = val_c;
        end
    end

    // Flags register: updated by arithmetic instructions only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '{sf: 1'b0, zf: 1'b1};
        end else if (run && is_alu) begin
            flags <= alu_fl;
        end
    end

    // Program counter and halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halted <= 1'b0;
        end else if (run) begin
            if (!legal) begin
                halted <= 1'b1;
            end else begin
                pc <= pc_next;
            end
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc)); // R9

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && is_alu) |=> $stable(flags)); // R5

    AST_ALU_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_alu) |=> (pc == $past(pc) + 64'd2)); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_jump) |=> (pc == $past(val_c))); // R8

    AST_LOAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> $stable(pc)); // R10

endmodule

// File: tb/sim_seq_core.sv
// sim_seq_core: self-checking bench for seq_core. Builds small programs,
// loads them under reset, runs to halt and compares architectural state
// against values computed arithmetically here.
module sim_seq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [7:0]  load_byte = '0;
    logic [3:0]  dbg_reg_sel = '0;
    logic [63:0] dbg_reg_val;
    logic [7:0]  dbg_mem_addr = '0;
    logic [7:0]  dbg_mem_byte;
    logic [63:0] pc;
    logic        halted;

    int tests = 0;
    int fails = 0;

    logic [7:0] prog [256];
    int         plen;

    always #10 clk = ~clk;

    seq_core u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_en      (load_en),
        .load_addr    (load_addr),
        .load_byte    (load_byte),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_val  (dbg_reg_val),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_byte (dbg_mem_byte),
        .pc           (pc),
        .halted       (halted)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic new_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        plen = 0;
    endtask

    task automatic put(input logic [7:0] b);
        prog[plen] = b;
        plen++;
    endtask

    task automatic put64(input logic [63:0] v);
        for (int k = 0; k < 8; k++) put(v[8*k +: 8]);
    endtask

    task automatic e_imm(input logic [3:0] rb, input logic [63:0] v);
        put(8'h30); put({4'hF, rb}); put64(v);
    endtask

    task automatic e_alu(input logic [3:0] fn, input logic [3:0] ra, input logic [3:0] rb);
        put({4'h6, fn}); put({ra, rb});
    endtask

    task automatic e_mov(input logic [3:0] fn, input logic [3:0] ra, input logic [3:0] rb);
        put({4'h2, fn}); put({ra, rb});
    endtask

    task automatic e_store(input logic [3:0] ra, input logic [3:0] rb, input logic [63:0] d);
        put(8'h40); put({ra, rb}); put64(d);
    endtask

    task automatic e_jump(input logic [63:0] d);
        put(8'h70); put64(d);
    endtask

    task automatic load_image();
        rst_n   = 1'b0;
        load_en = 1'b1;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            load_addr = 8'(a);
            load_byte = prog[a];
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (halted) break;
        end
        chk(tag, {63'd0, halted}, 64'd1);
    endtask

    task automatic run_prog(input string tag);
        load_image();
        rst_n = 1'b1;
        wait_halt(tag);
    endtask

    task automatic rd_reg(input logic [3:0] r, output logic [63:0] v);
        dbg_reg_sel = r;
        #1;
        v = dbg_reg_val;
    endtask

    task automatic rd_mem(input logic [7:0] a, output logic [7:0] v);
        dbg_mem_addr = a;
        #1;
        v = dbg_mem_byte;
    endtask

    function automatic logic [63:0] alu_ref(input int fn, input logic [63:0] a, input logic [63:0] b);
        case (fn)
            0:       return b + a;
            1:       return b - a;
            2:       return b & a;
            default: return b ^ a;
        endcase
    endfunction

    function automatic logic cond_ref(input int k, input logic sf, input logic zf);
        case (k)
            0:       return 1'b1;
            1:       return sf | zf;
            2:       return sf;
            3:       return zf;
            4:       return !zf;
            5:       return !sf;
            default: return !sf && !zf;
        endcase
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [7:0]  b;
        logic [63:0] ops [6];
        logic [63:0] fv [3];

        ops[0] = 64'd0;
        ops[1] = 64'd1;
        ops[2] = 64'd5;
        ops[3] = 64'h8000_0000_0000_0000;
        ops[4] = 64'hFFFF_FFFF_FFFF_FFFF;
        ops[5] = 64'h0123_4567_89AB_CDEF;

        // R1: reset state (image left loaded, reset held)
        new_prog();
        put(8'h00);
        load_image();
        @(negedge clk);
        chk("R1 pc", pc, 64'd0);
        chk("R1 halted", {63'd0, halted}, 64'd0);
        for (int r = 0; r < 15; r++) begin
            rd_reg(4'(r), v);
            chk("R1 reg", v, 64'd0);
        end

        // R5: flags after reset are sign=0, zero=1
        new_prog();
        e_imm(4'd3, 64'h77);
        e_mov(4'd3, 4'd3, 4'd1);
        e_mov(4'd4, 4'd3, 4'd2);
        e_mov(4'd2, 4'd3, 4'd6);
        put(8'h00);
        run_prog("R5 halt");
        rd_reg(4'd1, v); chk("R5 reset zero flag", v, 64'h77);
        rd_reg(4'd2, v); chk("R5 reset zero flag", v, 64'h0);
        rd_reg(4'd6, v); chk("R5 reset sign flag", v, 64'h0);

        // R4 R2 R3 R5: arithmetic sweep with flag readback
        for (int fn = 0; fn < 4; fn++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [63:0] exp;
                    exp = alu_ref(fn, ops[i], ops[j]);
                    new_prog();
                    e_imm(4'd0, ops[i]);
                    e_imm(4'd3, ops[j]);
                    e_alu(4'(fn), 4'd0, 4'd3);
                    e_imm(4'd8, 64'd1);
                    e_mov(4'd3, 4'd8, 4'd9);
                    e_mov(4'd2, 4'd8, 4'd10);
                    put(8'h00);
                    run_prog("R4 halt");
                    rd_reg(4'd3, v);  chk("R4 result", v, exp);
                    rd_reg(4'd0, v);  chk("R3 imm", v, ops[i]);
                    rd_reg(4'd9, v);  chk("R5 zero", v, {63'd0, exp == 64'd0});
                    rd_reg(4'd10, v); chk("R5 sign", v, {63'd0, exp[63]});
                    chk("R2 length pc", pc, 64'd36);
                end
            end
        end

        // R6: every move condition under positive, negative, zero flags
        fv[0] = 64'd1;
        fv[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        fv[2] = 64'd0;
        for (int s = 0; s < 3; s++) begin
            new_prog();
            e_imm(4'd0, fv[s]);
            e_alu(4'd2, 4'd0, 4'd0);
            e_imm(4'd3, 64'hACE);
            for (int k = 0; k < 7; k++) e_mov(4'(k), 4'd3, 4'((k < 2) ? k + 1 : k + 2));
            put(8'h00);
            run_prog("R6 halt");
            for (int k = 0; k < 7; k++) begin
                logic t;
                t = cond_ref(k, fv[s][63], fv[s] == 64'd0);
                rd_reg(4'((k < 2) ? k + 1 : k + 2), v);
                chk("R6 move", v, t ? 64'hACE : 64'h0);
            end
            rd_reg(4'd0, v); chk("R6 source", v, fv[s]);
        end

        // R7: base plus displacement store
        new_prog();
        e_imm(4'd0, 64'd2);
        e_imm(4'd3, 64'd8);
        e_store(4'd3, 4'd0, 64'd160);
        put(8'h00);
        run_prog("R7 halt");
        rd_mem(8'hA2, b); chk("R7 byte A2", {56'd0, b}, 64'h08);
        for (int a = 8'hA3; a <= 8'hA9; a++) begin
            rd_mem(8'(a), b); chk("R7 upper byte", {56'd0, b}, 64'h00);
        end
        rd_reg(4'd3, v); chk("R7 regs kept", v, 64'd8);

        // R7 R2: negative displacement, little-endian byte order
        new_prog();
        e_imm(4'd1, 64'h1122_3344_5566_7788);
        e_imm(4'd2, 64'h40);
        e_store(4'd1, 4'd2, 64'hFFFF_FFFF_FFFF_FFF8);
        put(8'h00);
        run_prog("R7 halt");
        for (int k = 0; k < 8; k++) begin
            logic [63:0] src;
            src = 64'h1122_3344_5566_7788;
            rd_mem(8'(8'h38 + k), b);
            chk("R2 store byte order", {56'd0, b}, {56'd0, src[8*k +: 8]});
        end

        // R8: jump over skipped code
        new_prog();
        e_jump(64'h20);
        e_imm(4'd0, 64'h55);
        plen = 32'h20;
        e_imm(4'd3, 64'h66);
        put(8'h00);
        run_prog("R8 halt");
        rd_reg(4'd0, v); chk("R8 skipped", v, 64'h0);
        rd_reg(4'd3, v); chk("R8 target", v, 64'h66);
        chk("R8 pc", pc, 64'h2A);

        // R9: illegal opcode halts and freezes state
        new_prog();
        e_imm(4'd0, 64'd5);
        put(8'hC0);
        e_imm(4'd0, 64'd9);
        run_prog("R9 halt");
        chk("R9 pc at halt", pc, 64'd10);
        repeat (20) @(negedge clk);
        chk("R9 pc frozen", pc, 64'd10);
        chk("R9 still halted", {63'd0, halted}, 64'd1);
        rd_reg(4'd0, v); chk("R9 reg frozen", v, 64'd5);

        // R10: loading stalls execution after reset is released
        new_prog();
        e_imm(4'd0, 64'h3C);
        put(8'h00);
        load_image();
        load_en   = 1'b1;
        load_addr = 8'hC8;
        load_byte = 8'h00;
        rst_n     = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 pc stalled", pc, 64'd0);
        rd_reg(4'd0, v); chk("R10 no write", v, 64'h0);
        load_en = 1'b0;
        wait_halt("R10 halt");
        rd_reg(4'd0, v); chk("R10 resumed", v, 64'h3C);

        // R11 R12: register code F as destination and source
        new_prog();
        e_imm(4'hF, 64'h99);
        e_imm(4'd0, 64'd7);
        e_mov(4'd0, 4'hF, 4'd0);
        put(8'h00);
        run_prog("R11 halt");
        rd_reg(4'd0, v); chk("R11 none reads zero", v, 64'h0);
        for (int r = 1; r < 15; r++) begin
            rd_reg(4'(r), v);
            chk("R11 write dropped", v, 64'h0);
        end
        rd_reg(4'hF, v); chk("R12 debug none", v, 64'h0);

        summary();
        $finish;
    end

endmodule